// File: doc/BRIEF.md
# Multi-Channel Ownership Mailbox

This peripheral lets several processors pass short messages to each other over a shared 32-bit register port. It holds a parameterised number of channels, and each channel has a 64-byte window of registers. A processor takes a free channel by writing its one-hot source ID to the channel's owner register and reading the ID back. While it owns the channel it fills the data words, picks the destination processors, sets the interrupt mask and the answer mode, then fires a send. The destinations receive an interrupt. The channel reaches its acknowledged state either at once (auto-answer) or when a destination answers. The owner clears the acknowledge and finally hands the channel back.

Every request carries the requester's one-hot ID on `req_src`, so the block can tell the owner from everyone else. One global key register guards all writes. After reset the block is locked, and it stays locked until the key value is written. Each processor has an interrupt line and a status word that lists the channels currently signalling it.

The request side has no back-pressure. A request presented with `req_valid` is taken in that cycle. A read returns its word with `rsp_valid` on the next cycle.

Top module: `hw_mailbox`

## Requirements
- R1: After reset every channel's mode register reads 0x10, its owner register reads 0, its mask register reads 0x3F, every `irq_o` bit is low, and the key register at 0xA00 reads 1 (locked).
- R2: While the key register reads 1, writes to channel registers have no effect, and reads still return current values. Writing 0x1ACCE551 to 0xA00 makes it read 0. Writing any other value makes it read 1 again.
- R3: Channel c's registers sit at c*0x40 + 4*i. Index 0 is the owner register. Suppose an idle channel's owner register is written with a one-hot value that equals `req_src`. The channel becomes owned: the owner register returns that ID and mode bits [7:4] read 0x2. A value that is not one-hot is ignored.
- R4: While a channel is owned, writes from any other `req_src` to its owner (0), destination-set (1), destination-clear (2), mode (4), mask (5), clear (6), send (7) or data (8..15) registers are ignored.
- R5: When the owner writes its own ID to the owner register, the channel returns to idle from any busy state. It then reads owner 0 and mode 0x10.
- R6: Mode bit 0 selects auto-answer. If it is set and the owner writes its own ID to the send register (7), mode bits [7:4] read 0x8.
- R7: If auto-answer is clear, the send leaves mode bits [7:4] at 0x4. A destination then writes its own ID to the send register, and bits [7:4] become 0x8. Register 3 reads the destination set. Register 1 ORs bits into that set, and register 2 clears bits from it.
- R8: In the acknowledged state, an owner write to register 6 that includes the owner's bit returns mode bits [7:4] to 0x2.
- R9: In state 0x4, a channel signals each processor in its destination set. In state 0x8, it signals its owner. A set bit in the channel's 6-bit mask blocks the signal to that processor. The word at 0x800 + 8*p has bit c set when channel c signals processor p, and `irq_o[p]` is the OR of that word.
- R10: A read accepted in one cycle raises `rsp_valid` with the addressed word on the next cycle. Otherwise `rsp_valid` is low. Unmapped addresses read 0.
- R11: The owner's writes to data word k (register 8+k) are stored and read back, including the last word at offset 0x3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | NUM_SRC | One-hot ID of the requesting processor |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| irq_o | output | NUM_SRC | Per-processor interrupt |

## Verification
The properties assume the following about the bus: every request lasts one cycle, `req_src` is zero or one-hot, and addresses are word aligned. Ownership and the one-hot owner property depend on these. The stimulus issues one request at a time followed by an idle cycle. It uses only the IDs 0x01, 0x02, 0x04 and one deliberately bad value (0x03), and that bad value is only used in a claim attempt that must be rejected. All other addresses used are exact register offsets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] LOCK_KEY = 32'h1ACCE551;

  localparam logic [3:0] REG_OWNER = 4'd0;
  localparam logic [3:0] REG_DSET  = 4'd1;
  localparam logic [3:0] REG_DCLR  = 4'd2;
  localparam logic [3:0] REG_DSTAT = 4'd3;
  localparam logic [3:0] REG_MODE  = 4'd4;
  localparam logic [3:0] REG_MASK  = 4'd5;
  localparam logic [3:0] REG_CLEAR = 4'd6;
  localparam logic [3:0] REG_SEND  = 4'd7;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_OWNED = 2'd1,
    CH_SENT  = 2'd2,
    CH_ACKED = 2'd3
  } ch_state_e;

  function automatic logic [3:0] state_nibble(ch_state_e s);
    case (s)
      CH_IDLE:  return 4'h1;
      CH_OWNED: return 4'h2;
      CH_SENT:  return 4'h4;
      default:  return 4'h8;
    endcase
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int NUM_CH = 4,
  parameter int NUM_SRC = 6,
  parameter int AW = 12,
  parameter logic [11:0] STAT_BASE = 12'h800,
  parameter logic [11:0] LOCK_ADDR = 12'hA00
) (
  input  logic [AW-1:0]   addr,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [3:0]      reg_idx,
  output logic            stat_hit,
  output logic [$clog2(NUM_SRC)-1:0] stat_idx,
  output logic            lock_hit
);
  localparam int SW = $clog2(NUM_SRC);

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit[c] = (addr[AW-1:6] == (AW-6)'(c));
  end

  assign reg_idx  = addr[5:2];
  assign stat_hit = (addr[AW-1:8] == STAT_BASE[AW-1:8]) && (addr[7:3] < 5'(NUM_SRC));
  assign stat_idx = addr[3+SW-1:3];
  assign lock_hit = (addr == LOCK_ADDR[AW-1:0]);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int NUM_DATA = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         reg_idx,
  input  logic [NUM_SRC-1:0] wr_src,
  input  logic [31:0]        wdata,
  output logic [31:0]        rd_word,
  output logic [1:0]         state_o,
  output logic [NUM_SRC-1:0] owner_o,
  output logic [NUM_SRC-1:0] irq_o
);
  ch_state_e state_q;
  logic [NUM_SRC-1:0] owner_q, mask_q, dest_q;
  logic auto_q;
  logic [NUM_DATA-1:0][31:0] data_q;

  logic [NUM_SRC-1:0] wsrc;
  logic upper_zero, is_owner, val_is_owner, val_is_req, req_onehot;

  assign wsrc         = wdata[NUM_SRC-1:0];
  assign upper_zero   = (wdata[31:NUM_SRC] == '0);
  assign is_owner     = (state_q != CH_IDLE) && (wr_src == owner_q);
  assign val_is_owner = upper_zero && (wsrc == owner_q);
  assign val_is_req   = upper_zero && (wsrc == wr_src);
  assign req_onehot   = $onehot(wr_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      owner_q <= '0;
      mask_q  <= '1;
      dest_q  <= '0;
      auto_q  <= 1'b0;
    end else if (wr_en) begin
      case (reg_idx)
        REG_OWNER: begin
          if (state_q == CH_IDLE && req_onehot && val_is_req) begin
            state_q <= CH_OWNED;
            owner_q <= wr_src;
          end else if (is_owner && val_is_owner) begin
            state_q <= CH_IDLE;
            owner_q <= '0;
            dest_q  <= '0;
            auto_q  <= 1'b0;
          end
        end
        REG_DSET:  if (is_owner) dest_q <= dest_q | wsrc;
        REG_DCLR:  if (is_owner) dest_q <= dest_q & ~wsrc;
        REG_MODE:  if (is_owner) auto_q <= wdata[0];
        REG_MASK:  if (is_owner) mask_q <= wsrc;
        REG_CLEAR: begin
          if (is_owner && state_q == CH_ACKED && (wsrc & owner_q) != '0)
            state_q <= CH_OWNED;
        end
        REG_SEND: begin
          if (state_q == CH_OWNED && is_owner && val_is_owner)
            state_q <= auto_q ? CH_ACKED : CH_SENT;
          else if (state_q == CH_SENT && req_onehot && val_is_req &&
                   (wr_src & dest_q) != '0)
            state_q <= CH_ACKED;
        end
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_DATA; k++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[k] <= '0;
      else if (wr_en && is_owner && reg_idx == 4'(8 + k))
        data_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    case (reg_idx)
      REG_OWNER: rd_word[NUM_SRC-1:0] = owner_q;
      REG_DSTAT: rd_word[NUM_SRC-1:0] = dest_q;
      REG_MODE:  rd_word[7:0] = {state_nibble(state_q), 3'b000, auto_q};
      REG_MASK:  rd_word[NUM_SRC-1:0] = mask_q;
      default: begin
        for (int k = 0; k < NUM_DATA; k++)
          if (reg_idx == 4'(8 + k)) rd_word = data_q[k];
      end
    endcase
  end

  always_comb begin
    case (state_q)
      CH_SENT:  irq_o = dest_q & ~mask_q;
      CH_ACKED: irq_o = owner_q & ~mask_q;
      default:  irq_o = '0;
    endcase
  end

  assign state_o = state_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/mbx_irq_map.sv
module mbx_irq_map #(
  parameter int NUM_CH = 4,
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_CH-1:0][NUM_SRC-1:0] ch_irq,
  output logic [NUM_SRC-1:0][NUM_CH-1:0] proc_stat,
  output logic [NUM_SRC-1:0]             irq_o
);
  for (genvar p = 0; p < NUM_SRC; p++) begin : g_proc
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign proc_stat[p][c] = ch_irq[c][p];
    end
    assign irq_o[p] = |proc_stat[p];
  end
endmodule

// File: rtl/hw_mailbox.sv
module hw_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_SRC = 6,
  parameter int NUM_DATA = 8,
  parameter int AW = 12,
  parameter logic [11:0] STAT_BASE = 12'h800,
  parameter logic [11:0] LOCK_ADDR = 12'hA00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [NUM_SRC-1:0] req_src,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam int SW = $clog2(NUM_SRC);

  logic [NUM_CH-1:0] ch_hit;
  logic [3:0] reg_idx;
  logic stat_hit, lock_hit;
  logic [SW-1:0] stat_idx;
  logic locked_q;

  logic [NUM_CH-1:0][31:0] ch_rd_w;
  logic [NUM_CH-1:0][1:0] ch_state_w;
  logic [NUM_CH-1:0][NUM_SRC-1:0] ch_owner_w, ch_irq_w;
  logic [NUM_SRC-1:0][NUM_CH-1:0] proc_stat_w;
  logic [31:0] rd_mux;

  mbx_decode #(
    .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .AW(AW),
    .STAT_BASE(STAT_BASE), .LOCK_ADDR(LOCK_ADDR)
  ) u_decode (
    .addr(req_addr), .ch_hit(ch_hit), .reg_idx(reg_idx),
    .stat_hit(stat_hit), .stat_idx(stat_idx), .lock_hit(lock_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      locked_q <= 1'b1;
    else if (req_valid && req_write && lock_hit)
      locked_q <= (req_wdata != LOCK_KEY);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbx_channel #(.NUM_SRC(NUM_SRC), .NUM_DATA(NUM_DATA)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(req_valid && req_write && !locked_q && ch_hit[c]),
      .reg_idx(reg_idx), .wr_src(req_src), .wdata(req_wdata),
      .rd_word(ch_rd_w[c]), .state_o(ch_state_w[c]),
      .owner_o(ch_owner_w[c]), .irq_o(ch_irq_w[c])
    );
  end

  mbx_irq_map #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_irq (
    .ch_irq(ch_irq_w), .proc_stat(proc_stat_w), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (lock_hit) rd_mux[0] = locked_q;
    for (int p = 0; p < NUM_SRC; p++)
      if (stat_hit && stat_idx == SW'(p)) rd_mux[NUM_CH-1:0] = proc_stat_w[p];
    for (int c = 0; c < NUM_CH; c++)
      if (ch_hit[c]) rd_mux = ch_rd_w[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/hw_mailbox_chk.sv
module hw_mailbox_chk #(
  parameter int NUM_CH = 4,
  parameter int NUM_SRC = 6,
  parameter int AW = 12,
  parameter logic [11:0] LOCK_ADDR = 12'hA00
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic [AW-1:0] req_addr,
  input logic rsp_valid,
  input logic [NUM_SRC-1:0] irq_o,
  input logic locked,
  input logic [NUM_CH-1:0][1:0] st,
  input logic [NUM_CH-1:0][NUM_SRC-1:0] owner
);
  logic any_busy;
  always_comb begin
    any_busy = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (st[c] != 2'd0) any_busy = 1'b1;
  end

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R10
  AST_LOCKED_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && req_valid && req_write && req_addr != LOCK_ADDR[AW-1:0]) |=> ($stable(st) && $stable(owner))); // R2
  AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> any_busy); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner[c])); // R3
    AST_IDLE_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (st[c] == 2'd0) |-> (owner[c] == '0)); // R5
  end
endmodule

bind hw_mailbox hw_mailbox_chk #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .AW(AW), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .irq_o(irq_o),
  .locked(locked_q), .st(ch_state_w), .owner(ch_owner_w)
);

// File: tb/test_hw_mailbox.sv
`timescale 1ns/1ps
module test_hw_mailbox;
  localparam int NCH = 4;
  localparam int NSRC = 6;
  localparam int ND = 8;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [NSRC-1:0] req_src = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [NSRC-1:0] irq_o;

  always #2 clk = ~clk;

  hw_mailbox i_hw_mailbox (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference: 0 idle, 1 owned, 2 sent, 3 acked
  int m_st[NCH];
  int unsigned m_own[NCH], m_auto[NCH], m_mask[NCH], m_dest[NCH];
  int unsigned m_dat[NCH][ND];
  bit m_lock;
  bit exp_rv;
  int unsigned exp_rd;

  function automatic int unsigned m_irq(int c);
    int unsigned raw;
    raw = (m_st[c] == 2) ? m_dest[c] : (m_st[c] == 3) ? m_own[c] : 0;
    return raw & ~m_mask[c] & 32'h3F;
  endfunction

  function automatic int unsigned m_irq_vec();
    int unsigned v = 0;
    for (int c = 0; c < NCH; c++) v |= m_irq(c);
    return v;
  endfunction

  function automatic int unsigned m_read(int unsigned a);
    int unsigned v = 0;
    int c, r, nib;
    if (a == 32'hA00) return m_lock;
    if (a >= 32'h800 && a < 32'h800 + NSRC * 8) begin
      for (int k = 0; k < NCH; k++)
        if ((m_irq(k) >> ((a - 32'h800) >> 3)) & 1) v |= (1 << k);
      return v;
    end
    if (a >= NCH * 64) return 0;
    c = a >> 6; r = (a >> 2) & 15;
    nib = (m_st[c] == 0) ? 1 : (m_st[c] == 1) ? 2 : (m_st[c] == 2) ? 4 : 8;
    case (r)
      0: return m_own[c];
      3: return m_dest[c];
      4: return (nib << 4) | m_auto[c];
      5: return m_mask[c];
      default: return (r >= 8) ? m_dat[c][r-8] : 0;
    endcase
  endfunction

  function automatic void m_write(int unsigned s, int unsigned a, int unsigned d);
    int c, r;
    bit own;
    if (a == 32'hA00) begin m_lock = (d != KEY); return; end
    if (m_lock || a >= NCH * 64) return;
    c = a >> 6; r = (a >> 2) & 15;
    own = (m_st[c] != 0) && (s == m_own[c]);
    case (r)
      0: if (m_st[c] == 0 && $countones(d) == 1 && d == s) begin
           m_st[c] = 1; m_own[c] = d;
         end else if (own && d == m_own[c]) begin
           m_st[c] = 0; m_own[c] = 0; m_auto[c] = 0; m_dest[c] = 0;
         end
      1: if (own) m_dest[c] |= d & 32'h3F;
      2: if (own) m_dest[c] &= ~d & 32'h3F;
      4: if (own) m_auto[c] = d & 1;
      5: if (own) m_mask[c] = d & 32'h3F;
      6: if (own && m_st[c] == 3 && (d & m_own[c]) != 0) m_st[c] = 1;
      7: if (m_st[c] == 1 && own && d == m_own[c]) m_st[c] = m_auto[c] ? 3 : 2;
         else if (m_st[c] == 2 && $countones(s) == 1 && (s & m_dest[c]) != 0 && d == s)
           m_st[c] = 3;
      default: if (r >= 8 && own) m_dat[c][r-8] = d;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 1; exp_rv = 0; exp_rd = 0;
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0; m_own[c] = 0; m_auto[c] = 0; m_mask[c] = 32'h3F; m_dest[c] = 0;
        for (int k = 0; k < ND; k++) m_dat[c][k] = 0;
      end
    end else begin
      exp_rv = req_valid && !req_write;
      if (exp_rv) exp_rd = m_read(32'(req_addr));
      if (req_valid && req_write) m_write(32'(req_src), 32'(req_addr), req_wdata);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
      if (exp_rv) check("R10 rsp_data", rsp_data, exp_rd);
      check("R9 irq_o", 32'(irq_o), m_irq_vec());
    end
  end

  function automatic logic [11:0] ad(int c, int r);
    return 12'(c * 64 + r * 4);
  endfunction

  task automatic wr(logic [NSRC-1:0] s, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_src = s; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd_chk(string tag, logic [NSRC-1:0] s, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_src = s; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(tag, rsp_data, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 mode idle", 6'h01, ad(0, 4), 32'h10);
    rd_chk("R1 mask ones", 6'h01, ad(1, 5), 32'h3F);
    rd_chk("R1 owner zero", 6'h01, ad(2, 0), 32'h0);
    rd_chk("R1 locked", 6'h01, 12'hA00, 32'h1);
    check("R1 irq low", 32'(irq_o), 32'h0);
    // R2 locked writes ignored
    wr(6'h02, ad(0, 0), 32'h2);
    rd_chk("R2 locked claim ignored", 6'h02, ad(0, 0), 32'h0);
    wr(6'h01, 12'hA00, KEY);
    rd_chk("R2 key unlocks", 6'h01, 12'hA00, 32'h0);
    // R3 claim
    wr(6'h02, ad(0, 0), 32'h2);
    rd_chk("R3 owner readback", 6'h02, ad(0, 0), 32'h2);
    rd_chk("R3 mode owned", 6'h02, ad(0, 4), 32'h20);
    wr(6'h03, ad(1, 0), 32'h3);
    rd_chk("R3 non-onehot ignored", 6'h01, ad(1, 0), 32'h0);
    // R4 non-owner writes
    wr(6'h04, ad(0, 0), 32'h4);
    rd_chk("R4 foreign claim ignored", 6'h04, ad(0, 0), 32'h2);
    wr(6'h04, ad(0, 8), 32'h1234);
    rd_chk("R4 foreign data ignored", 6'h04, ad(0, 8), 32'h0);
    wr(6'h04, ad(0, 5), 32'h0);
    rd_chk("R4 foreign mask ignored", 6'h04, ad(0, 5), 32'h3F);
    // R11 data words
    wr(6'h02, ad(0, 8), 32'hCAFE0001);
    wr(6'h02, ad(0, 15), 32'hBEEF000F);
    rd_chk("R11 data word 0", 6'h02, ad(0, 8), 32'hCAFE0001);
    rd_chk("R11 last data word", 6'h02, ad(0, 15), 32'hBEEF000F);
    // R6 auto-answer
    wr(6'h02, ad(0, 4), 32'h1);
    wr(6'h02, ad(0, 5), 32'h3D);
    rd_chk("R6 auto set", 6'h02, ad(0, 4), 32'h21);
    wr(6'h02, ad(0, 7), 32'h2);
    check("R9 irq to owner", 32'(irq_o), 32'h02);
    rd_chk("R6 acked", 6'h02, ad(0, 4), 32'h81);
    rd_chk("R9 status proc1", 6'h02, 12'h808, 32'h1);
    rd_chk("R9 status proc2 empty", 6'h02, 12'h810, 32'h0);
    // R8 clear ack
    wr(6'h02, ad(0, 6), 32'h2);
    rd_chk("R8 ack cleared", 6'h02, ad(0, 4), 32'h21);
    check("R8 irq dropped", 32'(irq_o), 32'h0);
    // R5 release
    wr(6'h02, ad(0, 0), 32'h2);
    rd_chk("R5 mode idle", 6'h02, ad(0, 4), 32'h10);
    rd_chk("R5 owner zero", 6'h02, ad(0, 0), 32'h0);
    // R7 manual answer on channel 2
    wr(6'h01, ad(2, 0), 32'h1);
    wr(6'h01, ad(2, 1), 32'h6);
    wr(6'h01, ad(2, 2), 32'h2);
    rd_chk("R7 dest set", 6'h01, ad(2, 3), 32'h4);
    wr(6'h01, ad(2, 5), 32'h0);
    wr(6'h01, ad(2, 7), 32'h1);
    check("R9 irq to dest", 32'(irq_o), 32'h04);
    rd_chk("R7 sent", 6'h01, ad(2, 4), 32'h40);
    rd_chk("R9 status proc2 ch2", 6'h01, 12'h810, 32'h4);
    wr(6'h04, ad(2, 7), 32'h4);
    check("R9 irq back to owner", 32'(irq_o), 32'h01);
    rd_chk("R7 answered", 6'h01, ad(2, 4), 32'h80);
    wr(6'h01, ad(2, 5), 32'h1);
    check("R9 masked", 32'(irq_o), 32'h0);
    wr(6'h01, ad(2, 0), 32'h1);
    rd_chk("R5 release from acked", 6'h01, ad(2, 4), 32'h10);
    // R2 relock
    wr(6'h01, 12'hA00, 32'h0);
    rd_chk("R2 relocked", 6'h01, 12'hA00, 32'h1);
    wr(6'h02, ad(3, 0), 32'h2);
    rd_chk("R2 relocked write ignored", 6'h02, ad(3, 0), 32'h0);
    rd_chk("R10 unmapped reads zero", 6'h01, 12'h900, 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule